// File: doc/BRIEF.md
# MAC Interrupt Status and Mask Unit

This block gathers the interrupt sources of an Ethernet MAC into one 8-bit status register. An 8-bit mask register selects which of those sources may drive a single level-sensitive interrupt line. Three status bits are copies of live conditions inside the MAC: a received frame waiting, an allocation result ready, and a transmit error pending. The MAC clears these itself, so host writes do not touch them. Two bits record one-cycle events: the transmit queue draining and a receive overrun. Each stays set until the host writes a 1 to its position.

A sixth bit summarises the protocol-handler causes. These are a failed transmission, a statistics counter wrapping, and a link fault. Each cause latches a pending flag when its event arrives. The flag reaches the status bit only while the matching enable bit in the cause-enable register is high. To clear a pending cause, the host writes the cause-enable register with that enable low, then writes it again with the enable high. A failed transmission also drops the transmitter enable. The transmitter stays off until the host sets the enable again.

The host reaches four byte registers through a simple synchronous write port with a combinational read path. The MAC datapath and the buffer allocator are outside this block.

Top module: `mac_irq_unit`

## Requirements
- R1: Reading offset 0 returns status with bit 0 = `rx_lvl_i`, bit 1 = `txerr_lvl_i` and bit 3 = `alloc_lvl_i`, each following its input in the same cycle. Bits 7:6 read 0. Writes to offset 0 have no effect on bits 0, 1 and 3.
- R2: Status bit 2 (transmit empty) is set by `txempty_ev_i`, and status bit 4 (receive overrun) is set by `rxovrn_ev_i`. Each is visible from the cycle after its event. Each stays set until a write to offset 0 with a 1 in that bit position. Writing 0 there leaves it set.
- R3: If an event and the write-1 clear of the same status bit fall in the same cycle, the bit is set afterwards.
- R4: The mask register at offset 1 reads back what was last written. `irq_o` is high exactly when some bit of (status AND mask) is 1.
- R5: Reset sets the mask, the latched status bits, the pending causes, the cause-enable register and the transmit enable to 0. `irq_o` stays low after reset until the mask is written, whatever the level inputs are.
- R6: `txfail_ev_i`, `cnt_roll_ev_i` and `link_err_ev_i` each set a pending flag whatever the enables are. Status bit 5 is 1 when some pending flag has its enable set. The enables are bit 5 (transmit fail), bit 6 (counter wrap) and bit 7 (link fault) of the cause-enable register at offset 2.
- R7: A write to offset 2 with an enable bit at 0 clears that cause's pending flag. A write with the bit at 1 keeps the flag. An event in the same cycle as a clearing write leaves the flag set.
- R8: `txfail_ev_i` clears the transmit enable (offset 3 bit 0, also driven on `tx_en_o`) from the next cycle on. The enable returns only when the host writes 1 to offset 3 bit 0. If a failure and that write fall in the same cycle, the enable ends up 0.
- R9: Offset 2 reads back its bits 7:5 with the other bits 0. Offset 3 reads back bit 0 with the other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| rx_lvl_i | input | 1 | Received frame waiting (level) |
| txerr_lvl_i | input | 1 | Transmit error status pending (level) |
| alloc_lvl_i | input | 1 | Allocation result ready (level) |
| txempty_ev_i | input | 1 | Transmit queue drained (pulse) |
| rxovrn_ev_i | input | 1 | Receive overrun (pulse) |
| txfail_ev_i | input | 1 | Transmission aborted by collision, carrier or SQE fault (pulse) |
| cnt_roll_ev_i | input | 1 | Statistics counter wrapped (pulse) |
| link_err_ev_i | input | 1 | Link fault detected (pulse) |
| tx_en_o | output | 1 | Transmitter enable |
| irq_o | output | 1 | Interrupt request, high level |

## Verification
The assertions assume that the event inputs are synchronous to `clk` and that each event is sampled for one cycle per occurrence. They also assume at most one register write per cycle, with `reg_addr` and `reg_wdata` valid whenever `reg_wr` is high. The stimulus changes every input just after the falling edge and holds it through the following rising edge, so each event and each write is seen exactly once. The bench covers the same-cycle collisions on purpose: an event together with its clear, and a failure together with a re-enable. These check the priority rules without breaking the one-sample-per-event assumption.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
    localparam int REG_W      = 8;
    localparam int ST_RX      = 0;
    localparam int ST_TXERR   = 1;
    localparam int ST_TXEMPTY = 2;
    localparam int ST_ALLOC   = 3;
    localparam int ST_RXOVRN  = 4;
    localparam int ST_PROTO   = 5;
    localparam int N_LATCHED  = 2;
    localparam int N_CAUSE    = 3;
    localparam int EN_BASE    = 5;
    localparam int TXC_EN_BIT = 0;
    localparam int LAT_TXEMPTY = 0;
    localparam int LAT_RXOVRN  = 1;
endpackage

// File: rtl/irq_event_latch.sv
module irq_event_latch #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } lat_state_t;

    lat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (ev_i[i]) begin
                st_d.flag[i] = 1'b1;
            end else if (clr_i[i]) begin
                st_d.flag[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R2
        event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev_i[g] |=> flag_o[g]);
        // R2
        clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !ev_i[g]) |=> !flag_o[g]);
        // R2
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[g] && !clr_i[g]) |=> flag_o[g]);
    end
endmodule

// File: rtl/irq_cause_pend.sv
module irq_cause_pend #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_i,
    input  logic         cfg_wr_i,
    input  logic [N-1:0] cfg_wdata_i,
    output logic [N-1:0] en_o,
    output logic         src_o
);
    typedef struct packed {
        logic [N-1:0] en;
        logic [N-1:0] pend;
    } cause_state_t;

    cause_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr_i) begin
            st_d.en = cfg_wdata_i;
        end
        for (int i = 0; i < N; i++) begin
            if (ev_i[i]) begin
                st_d.pend[i] = 1'b1;
            end else if (cfg_wr_i && !cfg_wdata_i[i]) begin
                st_d.pend[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o  = st_q.en;
    assign src_o = |(st_q.en & st_q.pend);

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R6
        enabled_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_i[g] && (cfg_wr_i ? cfg_wdata_i[g] : en_o[g])) |=> src_o);
        // R7
        disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr_i && !cfg_wdata_i[g] && !ev_i[g]) |=> !st_q.pend[g]);
    end
endmodule

// File: rtl/tx_enable_reg.sv
module tx_enable_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wbit_i,
    input  logic fail_i,
    output logic en_o
);
    typedef struct packed {
        logic en;
    } txc_state_t;

    txc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.en = wbit_i;
        end
        if (fail_i) begin
            st_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o = st_q.en;

    // R8
    fail_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_i |=> !en_o);
    // R8
    no_self_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !(wr_i && wbit_i)) |=> !en_o);
endmodule

// File: rtl/mac_irq_unit.sv
module mac_irq_unit
    import mac_irq_pkg::*;
#(
    parameter int ADDR_W     = 2,
    parameter int OFS_STATUS = 0,
    parameter int OFS_CTRL   = 2,
    parameter int OFS_TXC    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              rx_lvl_i,
    input  logic              txerr_lvl_i,
    input  logic              alloc_lvl_i,
    input  logic              txempty_ev_i,
    input  logic              rxovrn_ev_i,
    input  logic              txfail_ev_i,
    input  logic              cnt_roll_ev_i,
    input  logic              link_err_ev_i,
    output logic              tx_en_o,
    output logic              irq_o
);
    localparam int OFS_MASK = OFS_STATUS + 1;

    typedef struct packed {
        logic [REG_W-1:0] mask;
    } top_state_t;

    top_state_t st_d, st_q;

    logic sel_status, sel_mask, sel_ctrl, sel_txc;
    logic [N_LATCHED-1:0] lat_ev, lat_clr, lat_flag;
    logic [N_CAUSE-1:0]   cause_ev, cause_en;
    logic                 proto_src;
    logic [REG_W-1:0]     status;

    assign sel_status = (reg_addr == ADDR_W'(OFS_STATUS));
    assign sel_mask   = (reg_addr == ADDR_W'(OFS_MASK));
    assign sel_ctrl   = (reg_addr == ADDR_W'(OFS_CTRL));
    assign sel_txc    = (reg_addr == ADDR_W'(OFS_TXC));

    assign lat_ev[LAT_TXEMPTY]  = txempty_ev_i;
    assign lat_ev[LAT_RXOVRN]   = rxovrn_ev_i;
    assign lat_clr[LAT_TXEMPTY] = reg_wr && sel_status && reg_wdata[ST_TXEMPTY];
    assign lat_clr[LAT_RXOVRN]  = reg_wr && sel_status && reg_wdata[ST_RXOVRN];

    irq_event_latch #(.N(N_LATCHED)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_i   (lat_ev),
        .clr_i  (lat_clr),
        .flag_o (lat_flag)
    );

    assign cause_ev = {link_err_ev_i, cnt_roll_ev_i, txfail_ev_i};

    irq_cause_pend #(.N(N_CAUSE)) u_cause (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_i        (cause_ev),
        .cfg_wr_i    (reg_wr && sel_ctrl),
        .cfg_wdata_i (reg_wdata[EN_BASE +: N_CAUSE]),
        .en_o        (cause_en),
        .src_o       (proto_src)
    );

    tx_enable_reg u_txc (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (reg_wr && sel_txc),
        .wbit_i (reg_wdata[TXC_EN_BIT]),
        .fail_i (txfail_ev_i),
        .en_o   (tx_en_o)
    );

    always_comb begin
        status             = '0;
        status[ST_RX]      = rx_lvl_i;
        status[ST_TXERR]   = txerr_lvl_i;
        status[ST_TXEMPTY] = lat_flag[LAT_TXEMPTY];
        status[ST_ALLOC]   = alloc_lvl_i;
        status[ST_RXOVRN]  = lat_flag[LAT_RXOVRN];
        status[ST_PROTO]   = proto_src;
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr && sel_mask) begin
            st_d.mask = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (sel_status) begin
            reg_rdata = status;
        end else if (sel_mask) begin
            reg_rdata = st_q.mask;
        end else if (sel_ctrl) begin
            reg_rdata[EN_BASE +: N_CAUSE] = cause_en;
        end else if (sel_txc) begin
            reg_rdata[TXC_EN_BIT] = tx_en_o;
        end
    end

    assign irq_o = |(status & st_q.mask);

    // R4
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '0) |-> !irq_o);
    // R4
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel_mask) |=> (st_q.mask == $past(reg_wdata)));
    // R5
    reset_mask_chk: assert property (@(posedge clk)
        !rst_n |-> (st_q.mask == '0));
endmodule

// File: tb/mac_irq_unit_tb.sv
module mac_irq_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 8;
    // {rx, txerr, alloc, mask[7:0], expected irq}
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 8'h01, 1'b1},
        {1'b1, 1'b0, 1'b0, 8'h02, 1'b0},
        {1'b0, 1'b1, 1'b0, 8'h02, 1'b1},
        {1'b0, 1'b0, 1'b1, 8'h08, 1'b1},
        {1'b0, 1'b0, 1'b1, 8'hF7, 1'b0},
        {1'b1, 1'b1, 1'b1, 8'h00, 1'b0},
        {1'b1, 1'b1, 1'b1, 8'hFF, 1'b1},
        {1'b0, 1'b0, 1'b0, 8'hFF, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic rx_lvl = 0, txerr_lvl = 0, alloc_lvl = 0;
    logic txempty_ev = 0, rxovrn_ev = 0, txfail_ev = 0, roll_ev = 0, link_ev = 0;
    logic tx_en, irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_irq_unit u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_addr      (reg_addr),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .rx_lvl_i      (rx_lvl),
        .txerr_lvl_i   (txerr_lvl),
        .alloc_lvl_i   (alloc_lvl),
        .txempty_ev_i  (txempty_ev),
        .rxovrn_ev_i   (rxovrn_ev),
        .txfail_ev_i   (txfail_ev),
        .cnt_roll_ev_i (roll_ev),
        .link_err_ev_i (link_ev),
        .tx_en_o       (tx_en),
        .irq_o         (irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog expired act=%0d exp<%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // drive after a falling edge, captured on the next rising edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic step();
        @(negedge clk);
        txempty_ev = 0; rxovrn_ev = 0; txfail_ev = 0; roll_ev = 0; link_ev = 0;
    endtask

    initial begin
        @(negedge clk);
        rx_lvl = 1'b1;
        #1;
        // R5: reset state
        chk("R5 irq during reset", {7'b0, irq}, 8'h00);
        rd("R5 mask reset", 2'd1, 8'h00);
        rd("R5 ctrl reset", 2'd2, 8'h00);
        chk("R5 tx_en reset", {7'b0, tx_en}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd("R5 status after reset", 2'd0, 8'h01);
        chk("R5 irq low until mask written", {7'b0, irq}, 8'h00);
        rx_lvl = 1'b0;

        // R1 R4: table walk over level sources and masks
        for (int i = 0; i < NVEC; i++) begin
            wr(2'd1, VEC[i][8:1]);
            rx_lvl = VEC[i][11]; txerr_lvl = VEC[i][10]; alloc_lvl = VEC[i][9];
            #1;
            chk($sformatf("R4 irq vector %0d", i), {7'b0, irq}, {7'b0, VEC[i][0]});
            rd($sformatf("R1 status vector %0d", i), 2'd0,
               {4'b0, VEC[i][9], 1'b0, VEC[i][10], VEC[i][11]});
            rd($sformatf("R4 mask readback %0d", i), 2'd1, VEC[i][8:1]);
        end

        // R1: writes do not touch level bits
        rx_lvl = 1; txerr_lvl = 1; alloc_lvl = 1;
        wr(2'd0, 8'hFF);
        rd("R1 level bits ignore write", 2'd0, 8'h0B);
        rx_lvl = 0; txerr_lvl = 0; alloc_lvl = 0;
        #1;
        rd("R1 level bits follow inputs", 2'd0, 8'h00);

        // R2: latched transmit empty
        wr(2'd1, 8'h04);
        txempty_ev = 1; step();
        rd("R2 txempty latched", 2'd0, 8'h04);
        chk("R4 irq on txempty", {7'b0, irq}, 8'h01);
        wr(2'd0, 8'h00);
        rd("R2 write 0 keeps txempty", 2'd0, 8'h04);
        wr(2'd0, 8'h04);
        rd("R2 write 1 clears txempty", 2'd0, 8'h00);
        chk("R4 irq drops after clear", {7'b0, irq}, 8'h00);

        // R2: receive overrun, independent clear
        txempty_ev = 1; rxovrn_ev = 1; step();
        rd("R2 both latched", 2'd0, 8'h14);
        wr(2'd0, 8'h10);
        rd("R2 ovrn cleared alone", 2'd0, 8'h04);

        // R3: event and clear in one cycle
        txempty_ev = 1; rxovrn_ev = 1;
        reg_addr = 2'd0; reg_wdata = 8'h14; reg_wr = 1;
        step(); reg_wr = 0;
        rd("R3 set wins over clear", 2'd0, 8'h14);
        wr(2'd0, 8'h14);
        rd("R3 later clear works", 2'd0, 8'h00);

        // R6 R7: protocol-handler causes
        wr(2'd1, 8'h20);
        link_ev = 1; step();
        rd("R6 pending hidden while disabled", 2'd0, 8'h00);
        wr(2'd2, 8'h80);
        rd("R6 link pending shown once enabled", 2'd0, 8'h20);
        chk("R6 irq from proto source", {7'b0, irq}, 8'h01);
        wr(2'd2, 8'h80);
        rd("R7 write with enable high keeps", 2'd0, 8'h20);
        wr(2'd2, 8'h00);
        wr(2'd2, 8'h80);
        rd("R7 toggle clears link pending", 2'd0, 8'h00);
        roll_ev = 1; step();
        rd("R6 wrap cause masked by enable", 2'd0, 8'h00);
        wr(2'd2, 8'hC0);
        rd("R6 wrap cause enabled", 2'd0, 8'h20);
        roll_ev = 1;
        reg_addr = 2'd2; reg_wdata = 8'h80; reg_wr = 1;
        step(); reg_wr = 0;
        wr(2'd2, 8'hC0);
        rd("R7 event beats clearing write", 2'd0, 8'h20);
        wr(2'd2, 8'h00);

        // R9: readback widths
        wr(2'd2, 8'hFF);
        rd("R9 ctrl readback", 2'd2, 8'hE0);
        wr(2'd3, 8'hFF);
        rd("R9 txc readback", 2'd3, 8'h01);

        // R8: transmit failure drops the enable
        chk("R8 tx enabled", {7'b0, tx_en}, 8'h01);
        txfail_ev = 1; step();
        chk("R8 tx disabled by failure", {7'b0, tx_en}, 8'h00);
        rd("R6 txfail cause shown", 2'd0, 8'h20);
        step();
        rd("R8 stays off", 2'd3, 8'h00);
        wr(2'd3, 8'h01);
        chk("R8 host re-enable", {7'b0, tx_en}, 8'h01);
        txfail_ev = 1;
        reg_addr = 2'd3; reg_wdata = 8'h01; reg_wr = 1;
        step(); reg_wr = 0;
        chk("R8 failure beats re-enable", {7'b0, tx_en}, 8'h00);

        // R5: reset mid-run
        wr(2'd1, 8'hFF);
        rx_lvl = 1; txempty_ev = 1; step();
        rst_n = 0;
        #1;
        chk("R5 irq after reset", {7'b0, irq}, 8'h00);
        rd("R5 latched cleared", 2'd0, 8'h01);
        rd("R5 ctrl cleared", 2'd2, 8'h00);
        @(negedge clk);
        rst_n = 1;
        rx_lvl = 0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule